// File: doc/BRIEF.md
# Automatic Transmit/Receive Pin Controller

This block owns the general-purpose pins of a radio front-end card: several banks of pins, paired so that each card slot has a transmit-side bank and a receive-side bank. Every pin is driven either by a software-written output register or by automatic switching. Automatic switching chooses between two preset patterns. It uses the "transmit pattern" while the transmit FIFO reports that it holds data, and the "receive pattern" otherwise. Each bank also has an output-enable register. A pad model resolves each pin against the value the card drives back.

Software writes registers through a single-cycle address/data strobe. The output-enable and output-value registers take a merged write. The upper half of the data word says which bits to touch, and the lower half gives their new values. The three switching registers take the lower half-word whole. A readback port returns, for a selected slot, the resolved pin levels of both of its banks in one word.

Top module: `atr_gpio_ctrl`

## Requirements
- R1: After reset every register in every bank is zero. All output enables are 0, switching selects no pins, and readback shows only externally driven levels.
- R2: A write with register code 0 (output enable) changes only the enable bits whose mask bit, in data bits 31:16, is 1. Those bits take data bits 15:0, and all other enable bits keep their value.
- R3: A write with register code 1 (output value) updates the output register under the same per-bit mask rule as R2.
- R4: Writes with codes 2 (switch select), 3 (transmit pattern) and 4 (receive pattern) load data bits 15:0 in full. Data bits 31:16 have no effect on them.
- R5: A pin whose switch-select bit is 0 drives the bit of its bank's output-value register.
- R6: A pin whose switch-select bit is 1 drives the transmit-pattern bit while the registered FIFO flag is 1. It drives the receive-pattern bit while that flag is 0.
- R7: The FIFO flag is registered. A flag change first affects the pins after the next rising clock edge, and not during the cycle in which it changes.
- R8: A pin whose enable bit is 1 has a resolved level equal to its driven value. A pin whose enable bit is 0 is released, and its resolved level equals the external input.
- R9: Readback for slot s puts the resolved levels of bank 2s+1 (receive side) in bits 31:16 and those of bank 2s (transmit side) in bits 15:0.
- R10: The bank index is in address bits 1:0 and the register code in address bits 4:2. A write touches only the addressed bank. Register codes 5 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 5 | Bits 1:0 bank, bits 4:2 register code |
| wr_data | input | 32 | Bits 31:16 bit mask, bits 15:0 value |
| tx_fifo_nonempty | input | 1 | Transmit FIFO holds data |
| pad_ext | input | 64 | Level driven onto each pin from outside, bank b at bits 16b+15:16b |
| pad_out | output | 64 | Driven value of each pin |
| pad_oe | output | 64 | Output enable of each pin |
| rb_slot | input | 1 | Slot selected for readback |
| rb_data | output | 32 | Resolved levels of the selected slot's two banks |

## Verification
Directed writes first use masks that cover half a bank, then nibble masks on top of those. This separates a correct merge from a whole-word load or a load that ignores the mask. The switching registers are loaded with a non-zero upper half-word, so masked loading of them gives a visibly different pin pattern. A bank is then set up with mixed select bits and distinct output, transmit and receive patterns. The FIFO flag is toggled and the pins are sampled both before and after the next edge, which exposes a missing or doubled flag register. The external pad patterns differ from every driven pattern, so a swapped enable or swapped readback half shows up. A long random phase of writes to every register code and bank, flag changes and pad changes is then compared each cycle against a behavioural model.

// File: rtl/atr_gpio_pkg.sv
// Package: shared register codes for the automatic transmit/receive pin block.
// Assumes a 3-bit register code field in the write address.
package atr_gpio_pkg;

    localparam int REG_CODE_W = 3;

    typedef enum logic [REG_CODE_W-1:0] {
        RC_OE       = 3'd0,
        RC_OUT      = 3'd1,
        RC_SW_SEL   = 3'd2,
        RC_SW_TX    = 3'd3,
        RC_SW_RX    = 3'd4
    } reg_code_e;

endpackage

// File: rtl/atr_bank_regs.sv
// Module: register set of one pin bank (enable, output value, switch select,
// transmit pattern, receive pattern).
// Assumes the write strobe is already qualified by the bank decode; codes
// outside the defined set are ignored.
module atr_bank_regs
    import atr_gpio_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  logic [REG_CODE_W-1:0] wr_code,
    input  logic [PINS-1:0]       wr_mask,
    input  logic [PINS-1:0]       wr_val,
    output logic [PINS-1:0]       oe_q,
    output logic [PINS-1:0]       out_q,
    output logic [PINS-1:0]       sel_q,
    output logic [PINS-1:0]       txp_q,
    output logic [PINS-1:0]       rxp_q
);

    logic hit_oe, hit_out, hit_sel, hit_tx, hit_rx;

    // Decode which register of this bank the current write addresses.
    always_comb begin
        hit_oe  = wr_stb && (wr_code == RC_OE);
        hit_out = wr_stb && (wr_code == RC_OUT);
        hit_sel = wr_stb && (wr_code == RC_SW_SEL);
        hit_tx  = wr_stb && (wr_code == RC_SW_TX);
        hit_rx  = wr_stb && (wr_code == RC_SW_RX);
    end

    // Bit-masked merge for the enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      oe_q <= '0;
        else if (hit_oe) oe_q <= (oe_q & ~wr_mask) | (wr_val & wr_mask);
    end

    // Bit-masked merge for the output-value register.
    always_ff @(posedge clk) begin
        if (!rst_n)       out_q <= '0;
        else if (hit_out) out_q <= (out_q & ~wr_mask) | (wr_val & wr_mask);
    end

    // Whole-halfword loads for the three switching registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            txp_q <= '0;
            rxp_q <= '0;
        end else begin
            if (hit_sel) sel_q <= wr_val;
            if (hit_tx)  txp_q <= wr_val;
            if (hit_rx)  rxp_q <= wr_val;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (oe_q == '0 && out_q == '0 && sel_q == '0 &&
                          txp_q == '0 && rxp_q == '0));

    assert_oe_unmasked_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_oe |=> ((oe_q & ~$past(wr_mask)) == ($past(oe_q) & ~$past(wr_mask))));

    assert_out_unmasked_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_out |=> ((out_q & ~$past(wr_mask)) == ($past(out_q) & ~$past(wr_mask))));

    assert_idle_bank_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb && !$rose(rst_n)) |=> ($stable(oe_q) && $stable(out_q) && $stable(sel_q) &&
                       $stable(txp_q) && $stable(rxp_q)));

endmodule

// File: rtl/atr_pin_mux.sv
// Module: per-pin choice between the output-value register and the switching
// pattern picked by the registered FIFO flag.
// Assumes the flag input is already registered by the caller.
module atr_pin_mux #(
    parameter int PINS = 16
) (
    input  logic [PINS-1:0] out_reg,
    input  logic [PINS-1:0] sel_reg,
    input  logic [PINS-1:0] txp_reg,
    input  logic [PINS-1:0] rxp_reg,
    input  logic            tx_active,
    output logic [PINS-1:0] pin_val
);

    logic [PINS-1:0] pattern;

    // Pick the active switching pattern, then merge per pin.
    always_comb begin
        pattern = tx_active ? txp_reg : rxp_reg;
        pin_val = (out_reg & ~sel_reg) | (pattern & sel_reg);
    end

endmodule

// File: rtl/atr_pad_model.sv
// Module: tri-state pad resolution for one bank; an enabled pin shows its
// driven value, a released pin shows the external level.
// Assumes the external source never fights an enabled driver.
module atr_pad_model #(
    parameter int PINS = 16
) (
    input  logic [PINS-1:0] drv_val,
    input  logic [PINS-1:0] drv_oe,
    input  logic [PINS-1:0] ext_val,
    output logic [PINS-1:0] pad_val
);

    for (genvar p = 0; p < PINS; p++) begin : g_pad
        // Resolve one pin.
        always_comb pad_val[p] = drv_oe[p] ? drv_val[p] : ext_val[p];
    end

endmodule

// File: rtl/atr_gpio_ctrl.sv
// Module: top of the automatic transmit/receive pin controller.
// Decodes register writes to banks, registers the FIFO flag, drives the
// per-bank pin muxes and pad models, and forms the per-slot readback word.
// Assumes BANKS is a power of two, at least 4, with banks 2s and 2s+1
// forming slot s (transmit side even, receive side odd).
module atr_gpio_ctrl
    import atr_gpio_pkg::*;
#(
    parameter int PINS  = 16,
    parameter int BANKS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(BANKS)+REG_CODE_W-1:0] wr_addr,
    input  logic [2*PINS-1:0]         wr_data,
    input  logic                      tx_fifo_nonempty,
    input  logic [BANKS*PINS-1:0]     pad_ext,
    output logic [BANKS*PINS-1:0]     pad_out,
    output logic [BANKS*PINS-1:0]     pad_oe,
    input  logic [$clog2(BANKS)-2:0]  rb_slot,
    output logic [2*PINS-1:0]         rb_data
);

    localparam int BANK_W = $clog2(BANKS);
    localparam int ADDR_W = BANK_W + REG_CODE_W;

    logic [BANK_W-1:0]     wr_bank;
    logic [REG_CODE_W-1:0] wr_code;
    logic [PINS-1:0]       wr_mask;
    logic [PINS-1:0]       wr_val;
    logic                  tx_active_q;

    logic [PINS-1:0] b_oe   [BANKS];
    logic [PINS-1:0] b_out  [BANKS];
    logic [PINS-1:0] b_sel  [BANKS];
    logic [PINS-1:0] b_txp  [BANKS];
    logic [PINS-1:0] b_rxp  [BANKS];
    logic [PINS-1:0] b_pin  [BANKS];
    logic [PINS-1:0] b_pad  [BANKS];

    // Split the write address and data into fields.
    always_comb begin
        wr_bank = wr_addr[BANK_W-1:0];
        wr_code = wr_addr[ADDR_W-1:BANK_W];
        wr_mask = wr_data[2*PINS-1:PINS];
        wr_val  = wr_data[PINS-1:0];
    end

    // Register the FIFO occupancy flag that steers switching.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_active_q <= 1'b0;
        else        tx_active_q <= tx_fifo_nonempty;
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic bank_stb;

        // Qualify the write strobe for this bank.
        always_comb bank_stb = wr_en && (wr_bank == BANK_W'(b));

        atr_bank_regs #(.PINS(PINS)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (bank_stb),
            .wr_code (wr_code),
            .wr_mask (wr_mask),
            .wr_val  (wr_val),
            .oe_q    (b_oe[b]),
            .out_q   (b_out[b]),
            .sel_q   (b_sel[b]),
            .txp_q   (b_txp[b]),
            .rxp_q   (b_rxp[b])
        );

        atr_pin_mux #(.PINS(PINS)) u_mux (
            .out_reg   (b_out[b]),
            .sel_reg   (b_sel[b]),
            .txp_reg   (b_txp[b]),
            .rxp_reg   (b_rxp[b]),
            .tx_active (tx_active_q),
            .pin_val   (b_pin[b])
        );

        atr_pad_model #(.PINS(PINS)) u_pad (
            .drv_val (b_pin[b]),
            .drv_oe  (b_oe[b]),
            .ext_val (pad_ext[b*PINS +: PINS]),
            .pad_val (b_pad[b])
        );

        // Flatten this bank onto the pin buses.
        always_comb begin
            pad_out[b*PINS +: PINS] = b_pin[b];
            pad_oe[b*PINS +: PINS]  = b_oe[b];
        end

        assert_unswitched_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ((b_pin[b] ^ b_out[b]) & ~b_sel[b]) == '0);

        assert_switched_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
            tx_active_q |-> (((b_pin[b] ^ b_txp[b]) & b_sel[b]) == '0));

        assert_switched_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !tx_active_q |-> (((b_pin[b] ^ b_rxp[b]) & b_sel[b]) == '0));

        assert_released_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ((b_pad[b] ^ pad_ext[b*PINS +: PINS]) & ~b_oe[b]) == '0);
    end

    logic [BANK_W-1:0] rb_tx_idx;
    logic [BANK_W-1:0] rb_rx_idx;

    // Select the two banks of the requested slot for readback.
    always_comb begin
        rb_tx_idx = {rb_slot, 1'b0};
        rb_rx_idx = {rb_slot, 1'b1};
        rb_data   = {b_pad[rb_rx_idx], b_pad[rb_tx_idx]};
    end

    assert_flag_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$rose(rst_n) && !$stable(tx_fifo_nonempty)) |=> (tx_active_q == $past(tx_fifo_nonempty)));

endmodule

// File: tb/atr_gpio_ctrl_tb.sv
module atr_gpio_ctrl_tb;

    localparam int PINS  = 16;
    localparam int BANKS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tx_fifo_nonempty = 1'b0;
    logic [63:0] pad_ext = {16'h3C3C, 16'hC3C3, 16'h0F0F, 16'hA5A5};
    logic [63:0] pad_out;
    logic [63:0] pad_oe;
    logic [0:0]  rb_slot = 1'b0;
    logic [31:0] rb_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    logic [15:0] m_oe [4];
    logic [15:0] m_out [4];
    logic [15:0] m_sel [4];
    logic [15:0] m_tx [4];
    logic [15:0] m_rx [4];
    logic        m_flag;

    atr_gpio_ctrl #(.PINS(PINS), .BANKS(BANKS)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tx_fifo_nonempty(tx_fifo_nonempty),
        .pad_ext(pad_ext), .pad_out(pad_out), .pad_oe(pad_oe),
        .rb_slot(rb_slot), .rb_data(rb_data)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_pin(input int b);
        logic [15:0] pat;
        pat = m_flag ? m_tx[b] : m_rx[b];
        return (m_out[b] & ~m_sel[b]) | (pat & m_sel[b]);
    endfunction

    function automatic logic [15:0] exp_pad(input int b);
        return (exp_pin(b) & m_oe[b]) | (pad_ext[b*16 +: 16] & ~m_oe[b]);
    endfunction

    // reference model update on each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 4; b++) begin
                m_oe[b] = '0; m_out[b] = '0; m_sel[b] = '0; m_tx[b] = '0; m_rx[b] = '0;
            end
            m_flag = 1'b0;
        end else begin
            if (wr_en) begin
                int b;
                b = int'(wr_addr[1:0]);
                case (wr_addr[4:2])
                    3'd0: m_oe[b]  = (m_oe[b] & ~wr_data[31:16]) | (wr_data[15:0] & wr_data[31:16]);
                    3'd1: m_out[b] = (m_out[b] & ~wr_data[31:16]) | (wr_data[15:0] & wr_data[31:16]);
                    3'd2: m_sel[b] = wr_data[15:0];
                    3'd3: m_tx[b]  = wr_data[15:0];
                    3'd4: m_rx[b]  = wr_data[15:0];
                    default: ;
                endcase
            end
            m_flag = tx_fifo_nonempty;
        end
    end

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            for (int b = 0; b < 4; b++) begin
                check("R5/R6 pin value", {16'h0, pad_out[b*16 +: 16]}, {16'h0, exp_pin(b)});
                check("R2 enable", {16'h0, pad_oe[b*16 +: 16]}, {16'h0, m_oe[b]});
            end
            check("R9/R8 readback", rb_data,
                  {exp_pad(2*int'(rb_slot)+1), exp_pad(2*int'(rb_slot))});
        end
    end

    task automatic wr(input int bank, input int code, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = {3'(code), 2'(bank)};
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        rb_slot = 1'b0; #1;
        check("R1 oe zero", pad_oe[31:0], 32'h0);
        check("R1 oe zero hi", pad_oe[63:32], 32'h0);
        check("R1 readback slot0 external", rb_data, 32'h0F0F_A5A5);
        rb_slot = 1'b1; #1;
        check("R1 readback slot1 external", rb_data, 32'h3C3C_C3C3);
        rst_n = 1'b1;
        rb_slot = 1'b0;

        // R2: masked enable writes on bank 0
        wr(0, 0, 32'h00FF_FFFF);
        wr(0, 0, 32'hF0F0_0000);
        #1 check("R2 masked enable", {16'h0, pad_oe[15:0]}, 32'h0000_000F);

        // R3: masked output writes on bank 0
        wr(0, 1, 32'hFFFF_1234);
        wr(0, 1, 32'h0F00_FFFF);
        #1 check("R3 masked output", {16'h0, pad_out[15:0]}, 32'h0000_1F34);

        // R4/R5/R6: bank 1 with mixed select bits
        wr(1, 0, 32'hFFFF_FFFF);
        wr(1, 1, 32'hFFFF_5555);
        wr(1, 2, 32'h0000_FF00);
        wr(1, 3, 32'hABCD_1234);
        wr(1, 4, 32'h0000_9876);
        #1 check("R5/R6 receive pattern", {16'h0, pad_out[31:16]}, 32'h0000_9855);
        check("R8/R9 readback slot0", rb_data, 32'h9855_A5A4);

        // R7: flag takes effect only after the next edge
        @(negedge clk);
        tx_fifo_nonempty = 1'b1;
        #1 check("R7 no change before edge", {16'h0, pad_out[31:16]}, 32'h0000_9855);
        @(negedge clk);
        #1 check("R4/R6 transmit pattern", {16'h0, pad_out[31:16]}, 32'h0000_1255);
        @(negedge clk);
        tx_fifo_nonempty = 1'b0;
        @(negedge clk);
        #1 check("R7 back to receive", {16'h0, pad_out[31:16]}, 32'h0000_9855);

        // R9: slot 1 readback
        wr(2, 0, 32'hFFFF_FFFF);
        wr(2, 1, 32'hFFFF_BEEF);
        rb_slot = 1'b1; #1;
        check("R9 readback slot1", rb_data, 32'h3C3C_BEEF);

        // R10: undefined codes and other banks leave bank 2 untouched
        wr(2, 5, 32'hFFFF_0000);
        wr(2, 6, 32'hFFFF_0000);
        wr(2, 7, 32'hFFFF_0000);
        wr(3, 1, 32'hFFFF_1111);
        #1 check("R10 bank2 unchanged", {16'h0, pad_out[47:32]}, 32'h0000_BEEF);
        check("R10 bank3 written", {16'h0, pad_out[63:48]}, 32'h0000_1111);
        check("R10 bank2 enable unchanged", {16'h0, pad_oe[47:32]}, 32'h0000_FFFF);
        check("R10 readback slot1", rb_data, 32'h3C3C_BEEF);

        // random phase compared every cycle against the model
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            wr_en = ($urandom_range(0, 3) != 0);
            wr_addr = 5'($urandom_range(0, 31));
            wr_data = $urandom;
            if ($urandom_range(0, 4) == 0) tx_fifo_nonempty = ~tx_fifo_nonempty;
            if ($urandom_range(0, 7) == 0) pad_ext = {$urandom, $urandom};
            rb_slot = 1'($urandom_range(0, 1));
        end
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule